// File: doc/BRIEF.md
# CSR Read-Modify-Write Unit

This unit carries out control-and-status-register accesses for a small 64-bit processor core. Each request names one of three atomic operations (swap, set bits, clear bits), a 12-bit register address, an operand and the privilege level the core is running at. The operand is either a 64-bit register value or a 5-bit unsigned immediate widened with zeros. The unit answers one cycle later with the value the register held before the request, a writeback enable for the destination register and an illegal-instruction flag. When the access is allowed, the register is updated on the same clock edge.

Three registers are implemented:
- a fully writable scratch register;
- a status register in which only a masked group of bits can be written and a two-bit user word-width field always reads as the 64-bit code;
- a free-running cycle counter that can be read but not written.

Bits [9:8] of the address give the lowest privilege that may touch the register. An address with bits [11:10] equal to 2'b11 is read-only. An access that breaks either rule, names an unknown address, or uses the reserved operation code is refused and leaves every register unchanged.

The control is a two-state machine:
- `ST_IDLE` moves to `ST_RESP` when `req_vld` is high.
- `ST_RESP` stays in `ST_RESP` on a back-to-back request and otherwise returns to `ST_IDLE`.
- `rsp_vld` is high exactly while the machine is in `ST_RESP`.

Top module: `csr_rmw_unit`

## Requirements
- R1: After reset `rsp_vld` is 0, the scratch register reads 0, the writable status bits read 0, and the cycle counter restarts from 0.
- R2: A request sampled on a clock edge with `req_vld`=1 produces `rsp_vld`=1 for the following cycle. A request may be presented every cycle, and each request observes the update made by the one before it.
- R3: Swap (`req_op`=2'b01) returns the old value and writes the full operand. For the status register, only the bits in the writable mask are kept.
- R4: Set (`req_op`=2'b10) returns the old value and stores old OR operand. Example: scratch at 2, set with 4, returns 2 and leaves 6.
- R5: Clear (`req_op`=2'b11) returns the old value and stores old AND NOT operand. Example: scratch at 3, clear with 1, returns 3 and leaves 2.
- R6: With `req_imm`=1 the operand is `req_zimm` zero-extended to 64 bits and `req_rs1` is ignored. Otherwise the operation is the same.
- R7: A set or clear whose operand is zero performs no write. Such an access is therefore legal even on a read-only address.
- R8: When `req_priv` is less than `req_addr[9:8]` the access is illegal. Privilege codes are 00 user, 01 supervisor, 11 machine. Example: reading the status register (0x100) in user mode is illegal.
- R9: An access with write intent to an address with bits [11:10]=2'b11 is illegal. Write intent means a swap, or a set or clear with a nonzero operand. The cycle counter (0xC00) can be read and advances by one every clock.
- R10: An illegal access changes no register, and its response has `rsp_wb`=0 and `rsp_rdata`=0. A legal response has `rsp_wb`=1.
- R11: Status bits [33:32] always read 2'b10. Status bits outside the writable mask (default 0x00000000000C6122) and outside bits [33:32] read 0.
- R12: An address other than 0x100 (status), 0x140 (scratch) or 0xC00 (cycle) is illegal. The operation code 2'b00 is also illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request present this cycle |
| req_op | input | 2 | 01 swap, 10 set, 11 clear, 00 reserved |
| req_imm | input | 1 | Use the immediate as the operand |
| req_zimm | input | 5 | Unsigned immediate operand |
| req_rs1 | input | 64 | Register operand |
| req_addr | input | 12 | CSR address |
| req_priv | input | 2 | Current privilege level |
| rsp_vld | output | 1 | Response valid (state `ST_RESP`) |
| rsp_rdata | output | 64 | Value held before the access, 0 if illegal |
| rsp_illegal | output | 1 | Illegal-instruction exception |
| rsp_wb | output | 1 | Destination register write enable |

## Verification
The assertions assume that `req_op`, `req_addr`, `req_priv` and the operands hold stable for the whole cycle in which `req_vld` is high. They also assume the inputs carry no unknown values while a request is presented. The bench changes inputs only on falling clock edges and keeps every field at a defined value. It presents requests back to back, so each response is followed at once by the next request. Privilege code 2'b10 is swept like the other codes and is handled by plain numeric comparison.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

    typedef enum logic [1:0] {
        OP_RSV  = 2'b00,
        OP_SWAP = 2'b01,
        OP_SET  = 2'b10,
        OP_CLR  = 2'b11
    } csr_op_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_SCRATCH,
        SEL_CYCLE
    } csr_sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } rmw_state_e;

    localparam logic [11:0] ADDR_STATUS  = 12'h100;
    localparam logic [11:0] ADDR_SCRATCH = 12'h140;
    localparam logic [11:0] ADDR_CYCLE   = 12'hC00;

endpackage

// File: rtl/csr_access_check.sv
module csr_access_check
    import csr_rmw_pkg::*;
(
    input  csr_op_e     op,
    input  logic [11:0] addr,
    input  logic [1:0]  priv,
    input  logic        operand_nz,
    output csr_sel_e    sel,
    output logic        wr_intent,
    output logic        illegal
);
    logic priv_fail;
    logic ro_fail;

    always_comb begin
        unique case (addr)
            ADDR_STATUS:  sel = SEL_STATUS;
            ADDR_SCRATCH: sel = SEL_SCRATCH;
            ADDR_CYCLE:   sel = SEL_CYCLE;
            default:      sel = SEL_NONE;
        endcase
        wr_intent = (op == OP_SWAP) || (((op == OP_SET) || (op == OP_CLR)) && operand_nz);
        priv_fail = priv < addr[9:8];
        ro_fail   = (addr[11:10] == 2'b11) && wr_intent;
        illegal   = (sel == SEL_NONE) || (op == OP_RSV) || priv_fail || ro_fail;
    end

endmodule

// File: rtl/csr_rmw_alu.sv
module csr_rmw_alu
    import csr_rmw_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  csr_op_e         op,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] new_val
);
    always_comb begin
        unique case (op)
            OP_SWAP: new_val = operand;
            OP_SET:  new_val = old_val | operand;
            OP_CLR:  new_val = old_val & ~operand;
            default: new_val = old_val;
        endcase
    end

endmodule

// File: rtl/csr_file.sv
module csr_file
    import csr_rmw_pkg::*;
#(
    parameter int              XLEN         = 64,
    parameter logic [XLEN-1:0] STATUS_WMASK = 64'h0000_0000_000C_6122,
    parameter int              UXL_LSB      = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  csr_sel_e        sel,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rd_data,
    output logic [XLEN-1:0] scratch_q,
    output logic [XLEN-1:0] status_q
);
    localparam logic [XLEN-1:0] UXL_CODE = XLEN'(2) << UXL_LSB;

    logic [XLEN-1:0] cycle_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
            status_q  <= '0;
            cycle_q   <= '0;
        end else begin
            cycle_q <= cycle_q + 1'b1;
            if (we && sel == SEL_SCRATCH) scratch_q <= wdata;
            if (we && sel == SEL_STATUS)  status_q  <= wdata & STATUS_WMASK;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS:  rd_data = (status_q & STATUS_WMASK) | UXL_CODE;
            SEL_SCRATCH: rd_data = scratch_q;
            SEL_CYCLE:   rd_data = cycle_q;
            default:     rd_data = '0;
        endcase
    end

    // R9
    ro_never_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel == SEL_CYCLE));

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int              XLEN         = 64,
    parameter int              ZIMM_W       = 5,
    parameter logic [XLEN-1:0] STATUS_WMASK = 64'h0000_0000_000C_6122,
    parameter int              UXL_LSB      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [1:0]        req_op,
    input  logic              req_imm,
    input  logic [ZIMM_W-1:0] req_zimm,
    input  logic [XLEN-1:0]   req_rs1,
    input  logic [11:0]       req_addr,
    input  logic [1:0]        req_priv,
    output logic              rsp_vld,
    output logic [XLEN-1:0]   rsp_rdata,
    output logic              rsp_illegal,
    output logic              rsp_wb
);
    rmw_state_e      state_q, state_d;
    csr_op_e         op;
    csr_sel_e        sel;
    logic [XLEN-1:0] operand;
    logic [XLEN-1:0] old_val;
    logic [XLEN-1:0] new_val;
    logic [XLEN-1:0] scratch_q;
    logic [XLEN-1:0] status_q;
    logic            wr_intent;
    logic            illegal;
    logic            csr_we;

    assign op      = csr_op_e'(req_op);
    assign operand = req_imm ? XLEN'(req_zimm) : req_rs1;

    csr_access_check u_check (
        .op         (op),
        .addr       (req_addr),
        .priv       (req_priv),
        .operand_nz (operand != '0),
        .sel        (sel),
        .wr_intent  (wr_intent),
        .illegal    (illegal)
    );

    csr_rmw_alu #(.XLEN(XLEN)) u_alu (
        .op      (op),
        .old_val (old_val),
        .operand (operand),
        .new_val (new_val)
    );

    assign csr_we = req_vld && wr_intent && !illegal;

    csr_file #(
        .XLEN         (XLEN),
        .STATUS_WMASK (STATUS_WMASK),
        .UXL_LSB      (UXL_LSB)
    ) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (csr_we),
        .sel       (sel),
        .wdata     (new_val),
        .rd_data   (old_val),
        .scratch_q (scratch_q),
        .status_q  (status_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_vld ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_vld ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata   <= '0;
            rsp_illegal <= 1'b0;
        end else if (req_vld) begin
            rsp_rdata   <= illegal ? '0 : old_val;
            rsp_illegal <= illegal;
        end
    end

    // outputs
    always_comb begin
        rsp_vld = (state_q == ST_RESP);
        rsp_wb  = rsp_vld && !rsp_illegal;
    end

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    // R2
    no_resp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld);

    // R8
    low_priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_priv < req_addr[9:8]) |=> rsp_illegal);

    // R9
    ro_swap_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_addr[11:10] == 2'b11 && req_op == 2'b01) |=> rsp_illegal);

    // R10
    illegal_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_illegal) |-> (scratch_q == $past(scratch_q) && status_q == $past(status_q)));

    // R10
    wb_excludes_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> (rsp_wb != rsp_illegal));

endmodule

// File: tb/tb_csr_rmw_unit.sv
module tb_csr_rmw_unit;

    localparam logic [63:0] WMASK = 64'h0000_0000_000C_6122;
    localparam logic [63:0] UXL   = 64'h0000_0002_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic        req_imm = 1'b0;
    logic [4:0]  req_zimm = '0;
    logic [63:0] req_rs1 = '0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_priv = 2'b11;
    logic        rsp_vld;
    logic [63:0] rsp_rdata;
    logic        rsp_illegal;
    logic        rsp_wb;

    int checks = 0;
    int fails  = 0;
    logic [63:0] m_scratch = '0;
    logic [63:0] m_status  = '0;

    always #10 clk = ~clk;

    csr_rmw_unit dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op),
        .req_imm(req_imm), .req_zimm(req_zimm), .req_rs1(req_rs1),
        .req_addr(req_addr), .req_priv(req_priv), .rsp_vld(rsp_vld),
        .rsp_rdata(rsp_rdata), .rsp_illegal(rsp_illegal), .rsp_wb(rsp_wb)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge; leaves the request line high
    task automatic access(input logic [1:0] op, input logic imm, input logic [4:0] zimm,
                          input logic [63:0] rs1, input logic [11:0] addr, input logic [1:0] priv);
        req_vld = 1'b1; req_op = op; req_imm = imm; req_zimm = zimm;
        req_rs1 = rs1; req_addr = addr; req_priv = priv;
        @(negedge clk);
    endtask

    // model-driven access with full response checking (cycle data skipped)
    task automatic model_access(input string tag, input logic [1:0] op, input logic imm,
                                input logic [4:0] zimm, input logic [63:0] rs1,
                                input logic [11:0] addr, input logic [1:0] priv);
        logic [63:0] opnd, old, nv;
        logic known, wr, bad;
        opnd  = imm ? {59'b0, zimm} : rs1;
        known = (addr == 12'h100) || (addr == 12'h140) || (addr == 12'hC00);
        wr    = (op == 2'b01) || (op != 2'b00 && opnd != 64'd0);
        bad   = !known || op == 2'b00 || priv < addr[9:8] || (addr[11:10] == 2'b11 && wr);
        old   = (addr == 12'h140) ? m_scratch : (addr == 12'h100) ? ((m_status & WMASK) | UXL) : 64'd0;
        case (op)
            2'b01:   nv = opnd;
            2'b10:   nv = old | opnd;
            2'b11:   nv = old & ~opnd;
            default: nv = old;
        endcase
        access(op, imm, zimm, rs1, addr, priv);
        check({tag, " illegal"}, {63'b0, rsp_illegal}, {63'b0, bad});
        check({tag, " wb"}, {63'b0, rsp_wb}, {63'b0, !bad});
        check({tag, " valid"}, {63'b0, rsp_vld}, 64'd1);
        if (addr != 12'hC00 || bad) check({tag, " rdata"}, rsp_rdata, bad ? 64'd0 : old);
        if (!bad && wr && addr == 12'h140) m_scratch = nv;
        if (!bad && wr && addr == 12'h100) m_status = nv & WMASK;
    endtask

    initial begin
        #4_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] c0, c1;
        logic [11:0] addrs[4];
        logic [63:0] rs1s[3];
        logic [4:0]  zims[3];
        addrs = '{12'h100, 12'h140, 12'hC00, 12'h7C1};
        rs1s  = '{64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0BAD_1DEA_5A5A_0F0F};
        zims  = '{5'd0, 5'h1F, 5'h0A};

        repeat (3) @(negedge clk);
        check("R1 rsp_vld in reset", {63'b0, rsp_vld}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_vld after reset", {63'b0, rsp_vld}, 64'd0);
        access(2'b10, 1'b1, 5'd0, 64'd0, 12'h140, 2'b11);
        check("R1 scratch reset", rsp_rdata, 64'd0);
        access(2'b10, 1'b1, 5'd0, 64'd0, 12'h100, 2'b11);
        check("R11 status reset value", rsp_rdata, UXL);
        req_vld = 1'b0;
        @(negedge clk);
        check("R2 idle after request drops", {63'b0, rsp_vld}, 64'd0);

        // worked examples, back to back
        access(2'b01, 1'b1, 5'd3, 64'd0, 12'h140, 2'b01);
        access(2'b11, 1'b1, 5'd1, 64'd0, 12'h140, 2'b01);
        check("R5 clear returns old", rsp_rdata, 64'd3);
        access(2'b10, 1'b1, 5'd4, 64'd0, 12'h140, 2'b01);
        check("R4 set returns old (R2 sees prior update)", rsp_rdata, 64'd2);
        access(2'b01, 1'b1, 5'd2, 64'd0, 12'h140, 2'b01);
        check("R3 swap returns old", rsp_rdata, 64'd6);
        access(2'b01, 1'b0, 5'h1F, 64'h0BAD_1DEA, 12'h140, 2'b01);
        check("R6 register form ignores zimm", rsp_rdata, 64'd2);
        access(2'b11, 1'b0, 5'd0, 64'h0001_DEA, 12'h140, 2'b11);
        check("R5 clear register form", rsp_rdata, 64'h0BAD_1DEA);
        access(2'b10, 1'b0, 5'd0, 64'h000B_EEF, 12'h140, 2'b11);
        check("R4 set register form", rsp_rdata, 64'h0BAD_0000);
        access(2'b10, 1'b1, 5'd0, 64'hFFFF, 12'h140, 2'b11);
        check("R6 immediate ignores rs1", rsp_rdata, 64'h0BAD_BEEF);
        access(2'b10, 1'b1, 5'd0, 64'd0, 12'h140, 2'b11);
        check("R6 immediate zero left scratch", rsp_rdata, 64'h0BAD_BEEF);
        m_scratch = 64'h0BAD_BEEF;

        // cycle counter
        access(2'b10, 1'b1, 5'd0, 64'd0, 12'hC00, 2'b00);
        c0 = rsp_rdata;
        check("R7 zero-operand set on read-only is legal", {63'b0, rsp_illegal}, 64'd0);
        access(2'b11, 1'b0, 5'd0, 64'd0, 12'hC00, 2'b00);
        c1 = rsp_rdata;
        check("R9 cycle advances one per clock", c1 - c0, 64'd1);
        access(2'b01, 1'b0, 5'd0, 64'd0, 12'hC00, 2'b11);
        check("R9 cycle write illegal", {63'b0, rsp_illegal}, 64'd1);
        check("R10 illegal rdata zero", rsp_rdata, 64'd0);
        access(2'b10, 1'b1, 5'd0, 64'd0, 12'hC00, 2'b11);
        check("R9 cycle unchanged by refused write", rsp_rdata - c1, 64'd2);

        // privilege and status
        access(2'b10, 1'b1, 5'd0, 64'd0, 12'h100, 2'b00);
        check("R8 user read of status illegal", {63'b0, rsp_illegal}, 64'd1);
        access(2'b01, 1'b0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 12'h100, 2'b01);
        access(2'b10, 1'b1, 5'd0, 64'd0, 12'h100, 2'b01);
        check("R11 status masked with UXL", rsp_rdata, WMASK | UXL);
        access(2'b01, 1'b0, 5'd0, 64'd0, 12'h100, 2'b01);
        check("R11 status UXL survives zero write", rsp_rdata & ~WMASK, UXL);
        access(2'b10, 1'b1, 5'd0, 64'd0, 12'h7C1, 2'b11);
        check("R12 unknown address illegal", {63'b0, rsp_illegal}, 64'd1);
        m_status = '0;

        // near-exhaustive sweep
        for (int p = 0; p < 4; p++)
            for (int a = 0; a < 4; a++)
                for (int o = 0; o < 4; o++)
                    for (int im = 0; im < 2; im++)
                        for (int v = 0; v < 3; v++) begin
                            string tag;
                            logic known;
                            known = (a != 3);
                            if (!known || o == 0)            tag = "R12";
                            else if (p < addrs[a][9:8])      tag = "R8";
                            else if ((im ? zims[v] == 0 : rs1s[v] == 0) && o != 1) tag = "R7";
                            else if (a == 2)                 tag = "R9";
                            else if (a == 0)                 tag = "R11";
                            else if (im != 0)                tag = "R6";
                            else if (o == 1)                 tag = "R3";
                            else if (o == 2)                 tag = "R4";
                            else                             tag = "R5";
                            model_access(tag, 2'(o), im[0], zims[v], rs1s[v], addrs[a], 2'(p));
                        end

        // final readback confirms accumulated state (R10: refused writes left none)
        model_access("R10 final scratch", 2'b10, 1'b1, 5'd0, 64'd0, 12'h140, 2'b11);
        model_access("R10 final status", 2'b10, 1'b1, 5'd0, 64'd0, 12'h100, 2'b11);
        req_vld = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule